// File: doc/BRIEF.md
# Fast-to-Slow Clock Sequencer

This block turns a single fast clock into the schedule for a pipeline that moves once per slow period. It counts fast cycles through a fixed period, and it marks the cycles in which a shared lookup table may be read. It also marks the settling cycles that follow the reads. On the last cycle of each period it emits a one-cycle slow tick, which every pipeline stage uses as its clock enable. No second clock is created.

The period is the number of table reads plus the number of settling cycles. By default this is 20 reads and 1 spare cycle, so the fast clock is divided by 21. With a 350 MHz fast clock, that gives a slow rate of about 16.7 MHz. Logic that shares the table uses the step index to pick which operand is looked up in each read cycle. The reset input is asynchronous and active low. It is released to the counter through a small synchronizer.

Top module: `fsclk_sequencer`

## Requirements
- R1: `step_idx` advances by one on every fast clock edge while running, and wraps from PERIOD-1 to 0. PERIOD = NUM_READS + SETTLE_CYCLES, which is 21 by default.
- R2: `rd_strobe` is high exactly when `step_idx` is in 0 .. NUM_READS-1, and only while running.
- R3: `lookup_done` is high exactly when `step_idx` is in NUM_READS .. PERIOD-1, and only while running. It is never high together with `rd_strobe`.
- R4: `slow_tick` is a one-cycle pulse, high only when `step_idx` equals PERIOD-1. Consecutive ticks are exactly PERIOD fast cycles apart.
- R5: Exactly NUM_READS read strobes occur between two consecutive ticks, and between reset release and the first tick.
- R6: While `rst_n` is low, `step_idx` is 0 and `rd_strobe`, `lookup_done` and `slow_tick` are all low. Asserting `rst_n` takes effect at once, without waiting for a clock edge, including in the middle of a period.
- R7: After `rst_n` rises, the outputs stay idle for two rising edges. After the third rising edge, `step_idx` is 0 with `rd_strobe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_idx | output | $clog2(PERIOD) | Position within the slow period |
| rd_strobe | output | 1 | Table read slot in this cycle |
| lookup_done | output | 1 | All reads of this period issued; settling cycle |
| slow_tick | output | 1 | One-cycle pipeline advance enable, last cycle of the period |

## Verification
The bench builds two instances side by side. The first uses the default 20 reads and 1 settling cycle, so the exact divide-by-21 schedule is checked. The second uses 3 reads and 2 settling cycles, a period of 5. There, `lookup_done` and `slow_tick` differ, and many wraps fit into a short run. Every fast cycle of several whole periods is compared with an arithmetic model, for both instances. The bench also applies a reset in the middle of a period and checks the release latency again.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  // Per-cycle phase flags decoded from the step counter.
  typedef struct packed {
    logic rd;
    logic done;
    logic tick;
  } fsq_phase_t;

endpackage

// File: rtl/fsq_rst_sync.sv
module fsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign srst_n = pipe_q[STAGES-1];

endmodule

// File: rtl/fsq_step_ctr.sv
module fsq_step_ctr #(
  parameter int PERIOD = 21,
  parameter int W      = 5
) (
  input  logic         clk,
  input  logic         srst_n,
  output logic         run,
  output logic [W-1:0] step
);

  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic         run_q, run_d;
  logic [W-1:0] step_q, step_d;
  logic         step_en;

  // The run flag spends one cycle arming, so step 0 of the first period
  // is a full read slot.
  always_comb begin
    run_d   = 1'b1;
    step_en = run_q;
    step_d  = step_q;
    if (step_en) begin
      if (step_q == LAST) begin
        step_d = '0;
      end else begin
        step_d = step_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
    end else begin
      run_q  <= run_d;
      step_q <= step_d;
    end
  end

  assign run  = run_q;
  assign step = step_q;

endmodule

// File: rtl/fsq_phase_dec.sv
module fsq_phase_dec
  import fsq_pkg::*;
#(
  parameter int NUM_READS = 20,
  parameter int PERIOD    = 21,
  parameter int W         = 5
) (
  input  logic         run,
  input  logic [W-1:0] step,
  output fsq_phase_t   phase
);

  localparam logic [W-1:0] RD_END = W'(NUM_READS);
  localparam logic [W-1:0] LAST   = W'(PERIOD - 1);

  always_comb begin
    phase.rd   = run && (step < RD_END);
    phase.done = run && (step >= RD_END);
    phase.tick = run && (step == LAST);
  end

endmodule

// File: rtl/fsclk_sequencer.sv
module fsclk_sequencer
  import fsq_pkg::*;
#(
  parameter int NUM_READS     = 20,
  parameter int SETTLE_CYCLES = 1,
  parameter int SYNC_STAGES   = 2,
  localparam int PERIOD       = NUM_READS + SETTLE_CYCLES,
  localparam int STEP_W       = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STEP_W-1:0] step_idx,
  output logic              rd_strobe,
  output logic              lookup_done,
  output logic              slow_tick
);

  logic       srst_n;
  logic       run;
  fsq_phase_t phase;

  fsq_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fsq_step_ctr #(.PERIOD(PERIOD), .W(STEP_W)) u_ctr (
    .clk    (clk),
    .srst_n (srst_n),
    .run    (run),
    .step   (step_idx)
  );

  fsq_phase_dec #(.NUM_READS(NUM_READS), .PERIOD(PERIOD), .W(STEP_W)) u_dec (
    .run   (run),
    .step  (step_idx),
    .phase (phase)
  );

  assign rd_strobe   = phase.rd;
  assign lookup_done = phase.done;
  assign slow_tick   = phase.tick;

endmodule

// File: rtl/fsq_chk.sv
module fsq_chk #(
  parameter int NUM_READS = 20,
  parameter int PERIOD    = 21,
  parameter int W         = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] step,
  input logic         rd,
  input logic         done,
  input logic         tick
);

  localparam int CW = $clog2(PERIOD + 1) + 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [CW-1:0] rd_cnt;
  logic [CW-1:0] gap_cnt;
  logic          seen_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt    <= '0;
      gap_cnt   <= '0;
      seen_tick <= 1'b0;
    end else begin
      if (tick) begin
        rd_cnt    <= '0;
        gap_cnt   <= '0;
        seen_tick <= 1'b1;
      end else begin
        gap_cnt <= gap_cnt + CW'(1);
        if (rd) rd_cnt <= rd_cnt + CW'(1);
      end
    end
  end

  // R1
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || done) && step != LAST) |=> (step == W'($past(step) + W'(1))));

  // R1
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (step == '0 && rd));

  // R2
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (step < W'(NUM_READS)));

  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && done));

  // R4
  tick_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (done && step == LAST));

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_tick) |-> (gap_cnt == CW'(PERIOD - 1)));

  // R5
  rd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (rd_cnt == CW'(NUM_READS)));

  // R6
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (step == '0 && !rd && !done && !tick));

endmodule

bind fsclk_sequencer fsq_chk #(
  .NUM_READS (NUM_READS),
  .PERIOD    (PERIOD),
  .W         (STEP_W)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .step (step_idx),
  .rd   (rd_strobe),
  .done (lookup_done),
  .tick (slow_tick)
);

// File: tb/sim_fsclk_sequencer.sv
module sim_fsclk_sequencer;

  localparam int NR0 = 20;
  localparam int ST0 = 1;
  localparam int P0  = NR0 + ST0;
  localparam int W0  = $clog2(P0);
  localparam int NR1 = 3;
  localparam int ST1 = 2;
  localparam int P1  = NR1 + ST1;
  localparam int W1  = $clog2(P1);

  logic clk;
  logic rst_n;

  logic [W0-1:0] step0;
  logic          rd0, done0, tick0;
  logic [W1-1:0] step1;
  logic          rd1, done1, tick1;

  int nchk;
  int nerr;
  int last_tick [2];
  int rd_seen [2];

  fsclk_sequencer #(.NUM_READS(NR0), .SETTLE_CYCLES(ST0)) u0 (
    .clk(clk), .rst_n(rst_n), .step_idx(step0),
    .rd_strobe(rd0), .lookup_done(done0), .slow_tick(tick0)
  );

  fsclk_sequencer #(.NUM_READS(NR1), .SETTLE_CYCLES(ST1)) u1 (
    .clk(clk), .rst_n(rst_n), .step_idx(step1),
    .rd_strobe(rd1), .lookup_done(done1), .slow_tick(tick1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "u0 step", int'(step0), 0);
    chk(req, "u0 rd/done/tick", int'({rd0, done0, tick0}), 0);
    chk(req, "u1 step", int'(step1), 0);
    chk(req, "u1 rd/done/tick", int'({rd1, done1, tick1}), 0);
  endtask

  // Compare one instance against the model for running cycle j.
  task automatic check_run(input int id, input int j, input int nr, input int p,
                           input int st, input logic rd, input logic dn, input logic tk);
    int es;
    es = j % p;
    chk("R1", $sformatf("u%0d step j=%0d", id, j), st, es);
    chk("R2", $sformatf("u%0d rd j=%0d", id, j), int'(rd), int'(es < nr));
    chk("R3", $sformatf("u%0d done j=%0d", id, j), int'(dn), int'(es >= nr));
    chk("R4", $sformatf("u%0d tick j=%0d", id, j), int'(tk), int'(es == p - 1));
    if (rd) rd_seen[id]++;
    if (tk) begin
      chk("R5", $sformatf("u%0d reads in period", id), rd_seen[id], nr);
      if (last_tick[id] >= 0)
        chk("R4", $sformatf("u%0d tick spacing", id), j - last_tick[id], p);
      last_tick[id] = j;
      rd_seen[id]   = 0;
    end
  endtask

  task automatic release_and_sweep(input int ncyc);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check_idle("R7");
    end
    for (int i = 0; i < 2; i++) begin
      last_tick[i] = -1;
      rd_seen[i]   = 0;
    end
    for (int j = 0; j < ncyc; j++) begin
      @(negedge clk);
      if (j == 0) chk("R7", "first read slot after release", int'(rd0 && rd1), 1);
      check_run(0, j, NR0, P0, int'(step0), rd0, done0, tick0);
      check_run(1, j, NR1, P1, int'(step1), rd1, done1, tick1);
    end
  endtask

  initial begin
    #(20 * 200000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    nchk  = 0;
    nerr  = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R6");

    release_and_sweep(5 * P0);

    // Reset in the middle of a period: takes effect without a clock edge.
    repeat (7) @(negedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check_idle("R6");
    repeat (3) begin
      @(negedge clk);
      check_idle("R6");
    end

    release_and_sweep(3 * P0 + 4);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule